// File: doc/BRIEF.md
# I2C Slave Byte Engine

This block is the receive and transmit core of an I2C slave. It oversamples the SCL and SDA lines with a fast internal clock and finds START and STOP conditions. It shifts a programmable number of bits per transfer, from one to eight, and can append a ninth clock for the acknowledge bit. When a transfer completes, it raises an interrupt request and rewinds its bit-count field to zero. The SDA pin is open-drain: the block only ever pulls the line low, through an output-enable pin.

The block has two operating formats. In addressed format, the first byte after a START is compared with a stored 7-bit slave address and with the general-call address. Later bytes are accepted only if that comparison succeeded. In free format, no address is checked and every byte is passed to software.

Software controls the block through a small write port with three registers: control, slave address and data. The block reports a status word, the data register, the control register and a timeout flag. An external timeout counter can set the timeout flag; this block only clears it. Clearing the enable bit, or writing the self-clearing soft-reset bit, returns all flags to their idle values.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, the outputs are as follows: status is 0x10 (only the not-pending bit, bit 4, is set), sda_oe is 0, irq is 0, data_q is 0x00 and ctrl_q is 0x00.
- R2: A START (SDA falling while SCL is high) sets the bus-busy bit (status bit 5) and forces the bit-count field (ctrl bits 2:0) to 000. A STOP (SDA rising while SCL is high) clears bus-busy.
- R3: In addressed format (ctrl bit 4 = 0), the first byte after a START is always 8 bits. If bits 7:1 of that byte equal the stored slave address (register 1, bits 6:0), the block sets the own-address bit (status bit 2), copies received bit 0 into the transmit-direction bit (status bit 6) and raises irq. For a write address (bit 0 = 0), the byte is stored in data_q.
- R4: The received byte 0x00 is the general call. It sets status bit 1 and never sets status bit 2. Any other address that does not match gets no acknowledge and no irq, and the bytes that follow it, up to the next START, leave data_q and irq unchanged.
- R5: With the acknowledge-clock option on (ctrl bit 5 = 1), one extra clock follows the data bits. During that clock the block pulls SDA low (sda_oe = 1) for an accepted received byte, and irq rises on that clock. With the option off, irq rises on the last data bit and no extra clock is used. sda_oe only ever rises while SCL is low.
- R6: A bit-count field of n = 1..7 makes the next data transfer n bits long, and 000 makes it 8 bits. Received bits are stored right-aligned in data_q, with the upper bits cleared. On completion, the field returns to 000.
- R7: In free format (ctrl bit 4 = 1), every byte, including the first one after a START, is acknowledged, stored in data_q and signalled on irq. Status bits 2 and 1 stay 0.
- R8: While the interface is disabled (ctrl bit 3 = 0), several things hold. sda_oe is 0. status reads 0x10. The timeout flag is cleared. Writes to the data register (register 2) leave data_q unchanged.
- R9: While the interface is enabled, writing 1 to the soft-reset bit (ctrl bit 6) returns status to 0x10 and clears the timeout flag within 3 clock cycles. The soft-reset bit then reads 0 again, and the other control bits are kept.
- R10: irq equals the inverse of the not-pending bit (status bit 4). A write to the data register while the interface is enabled sets that bit again, which clears irq.
- R11: After an acknowledged read address (bit 0 = 1), the block sends the data register MSB first. It pulls SDA low for each 0 bit, changes SDA only while SCL is low, and releases SDA for the master's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 slave address, 2 data |
| reg_wdata | input | 8 | Register write data |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| tmo_set | input | 1 | Pulse from an external timeout counter that sets the timeout flag |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| ctrl_q | output | 8 | Control register: bits 2:0 bit count, 3 enable, 4 free format, 5 ack clock, 6 soft reset |
| data_q | output | 8 | Data register (received byte or byte to send) |
| status | output | 8 | Status: 7 master (0), 6 transmit, 5 busy, 4 not-pending, 3 lost (0), 2 own address, 1 general call, 0 last ack bit |
| tmo_flag | output | 1 | Timeout flag |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
Several properties are checked on every cycle. A disabled interface stays silent with idle status. The soft-reset bit self-clears and leaves idle status behind. Every START and every interrupt coincides with a zero bit-count field. The two address-hit flags are never set together. SDA is only ever pulled while SCL is low.

Other behaviours need a whole bus transaction, so only the directed scenarios can show them. These include address matching and mismatching, general calls, right-aligned short transfers, free format, transmission of the data register, and data writes being ignored while the interface is disabled.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } eng_state_t;

  // control register field positions
  localparam int CTL_EN     = 3;
  localparam int CTL_FREE   = 4;
  localparam int CTL_ACKCLK = 5;
  localparam int CTL_SRST   = 6;

  // register select codes
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_SLV  = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;

  localparam logic [7:0] STATUS_IDLE = 8'h10;
endpackage

// File: rtl/i2cbe_sync.sv
module i2cbe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q, scl_pipe_d, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        scl_pipe_d = scl_in;
        sda_pipe_d = sda_in;
      end
    end else begin : g_many
      always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_in};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_pipe_q[STAGES-1];
    sda_s     = sda_pipe_q[STAGES-1];
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end
endmodule

// File: rtl/i2cbe_regs.sv
module i2cbe_regs
  import i2cbe_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 2,
  localparam int SAW = DW - 1,
  localparam int BCW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           clr_bc,
  input  logic           tmo_set,
  output logic [DW-1:0]  ctrl_q,
  output logic [SAW-1:0] slv_q,
  output logic           tmo_q,
  output logic           dat_we,
  output logic           int_clr
);
  logic [DW-1:0]  ctrl_d;
  logic [SAW-1:0] slv_d;
  logic           tmo_d;

  always_comb begin
    int_clr = ~ctrl_q[CTL_EN] | ctrl_q[CTL_SRST];
    ctrl_d  = ctrl_q;
    slv_d   = slv_q;
    tmo_d   = tmo_q;
    ctrl_d[CTL_SRST] = 1'b0;
    if (we && addr == AW'(RA_CTRL)) begin
      ctrl_d = wdata;
      ctrl_d[DW-1] = 1'b0;
      ctrl_d[CTL_SRST] = wdata[CTL_SRST] & wdata[CTL_EN];
    end
    if (clr_bc) ctrl_d[BCW-1:0] = '0;
    if (we && addr == AW'(RA_SLV)) slv_d = wdata[SAW-1:0];
    if (tmo_set) tmo_d = 1'b1;
    if (int_clr) tmo_d = 1'b0;
    dat_we = we && (addr == AW'(RA_DATA)) && !int_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      slv_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      slv_q  <= slv_d;
      tmo_q  <= tmo_d;
    end
  end
endmodule

// File: rtl/i2cbe_engine.sv
module i2cbe_engine
  import i2cbe_pkg::*;
#(
  parameter int DW  = 8,
  localparam int SAW = DW - 1,
  localparam int BCW = $clog2(DW),
  localparam int CW  = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           int_clr,
  input  logic           start_det,
  input  logic           stop_det,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           sda_s,
  input  logic [BCW-1:0] bc,
  input  logic           free_fmt,
  input  logic           ack_clk,
  input  logic [SAW-1:0] slv,
  input  logic           dat_we,
  input  logic [DW-1:0]  dat_wdata,
  output logic           clr_bc,
  output logic [DW-1:0]  data_q,
  output logic [7:0]     status,
  output logic           sda_oe
);
  eng_state_t     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d, cnt_inc, tgt, tx_idx;
  logic [DW-1:0]  sh_q, sh_d, sh_new, data_d;
  logic           acc_q, acc_d, isad_q, isad_d, ackd_q, ackd_d, oe_q, oe_d;
  logic           trx_q, trx_d, bb_q, bb_d, pin_q, pin_d;
  logic           aas_q, aas_d, gc_q, gc_d, lrb_q, lrb_d;
  logic           hit, gcall, acc_new, trx_new;

  always_comb begin
    tgt     = (st_q == ST_ADDR || bc == '0) ? CW'(DW) : CW'(bc);
    sh_new  = {sh_q[DW-2:0], sda_s};
    cnt_inc = cnt_q + CW'(1);
    tx_idx  = CW'(DW - 1) - cnt_q;
    gcall   = !free_fmt && (sh_new == '0);
    hit     = !free_fmt && !gcall && (sh_new[DW-1:1] == slv);
    acc_new = free_fmt | hit | gcall;
    trx_new = hit & sh_new[0];
  end

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  sh_d = sh_q;  data_d = data_q;
    acc_d = acc_q;  isad_d = isad_q;  ackd_d = ackd_q;  oe_d = oe_q;
    trx_d = trx_q;  bb_d = bb_q;  pin_d = pin_q;
    aas_d = aas_q;  gc_d = gc_q;  lrb_d = lrb_q;
    clr_bc = 1'b0;
    if (int_clr) begin
      st_d = ST_IDLE;  cnt_d = '0;  sh_d = '0;  acc_d = 1'b0;  isad_d = 1'b0;
      ackd_d = 1'b0;  oe_d = 1'b0;  trx_d = 1'b0;  bb_d = 1'b0;  pin_d = 1'b1;
      aas_d = 1'b0;  gc_d = 1'b0;  lrb_d = 1'b0;
    end else begin
      if (dat_we) begin
        data_d = dat_wdata;
        pin_d  = 1'b1;
      end
      if (start_det) begin
        st_d = ST_ADDR;  cnt_d = '0;  sh_d = '0;  acc_d = 1'b0;  ackd_d = 1'b0;
        oe_d = 1'b0;  trx_d = 1'b0;  bb_d = 1'b1;  aas_d = 1'b0;  gc_d = 1'b0;
        clr_bc = 1'b1;
      end else if (stop_det) begin
        st_d = ST_IDLE;  bb_d = 1'b0;  oe_d = 1'b0;
      end else if (scl_rise) begin
        unique case (st_q)
          ST_ADDR, ST_DATA: begin
            if (cnt_inc == tgt) begin
              cnt_d = '0;
              sh_d  = '0;
              if (st_q == ST_ADDR) begin
                isad_d = 1'b1;
                acc_d  = acc_new;
                aas_d  = hit;
                gc_d   = gcall;
                trx_d  = trx_new;
                if (acc_new && !trx_new) data_d = sh_new;
              end else begin
                isad_d = 1'b0;
                if (acc_q && !trx_q) data_d = sh_new;
              end
              if (ack_clk) begin
                st_d   = ST_ACK;
                ackd_d = 1'b0;
              end else begin
                st_d = ((st_q == ST_ADDR) ? acc_new : acc_q) ? ST_DATA : ST_SKIP;
                if ((st_q == ST_ADDR) ? acc_new : acc_q) begin
                  pin_d  = 1'b0;
                  clr_bc = 1'b1;
                end
              end
            end else begin
              cnt_d = cnt_inc;
              sh_d  = sh_new;
            end
          end
          ST_ACK: begin
            if (!ackd_q) begin
              ackd_d = 1'b1;
              lrb_d  = sda_s;
              if (acc_q) begin
                pin_d  = 1'b0;
                clr_bc = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (st_q)
          ST_ACK: begin
            if (ackd_q) begin
              st_d   = acc_q ? ST_DATA : ST_SKIP;
              ackd_d = 1'b0;
              oe_d   = acc_q & trx_q & ~data_q[DW-1];
            end else begin
              oe_d = acc_q & (isad_q | ~trx_q);
            end
          end
          ST_DATA: oe_d = acc_q & trx_q & ~data_q[tx_idx[BCW-1:0]];
          default: oe_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  data_q <= '0;
      acc_q <= 1'b0;  isad_q <= 1'b0;  ackd_q <= 1'b0;  oe_q <= 1'b0;
      trx_q <= 1'b0;  bb_q <= 1'b0;  pin_q <= 1'b1;
      aas_q <= 1'b0;  gc_q <= 1'b0;  lrb_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  sh_q <= sh_d;  data_q <= data_d;
      acc_q <= acc_d;  isad_q <= isad_d;  ackd_q <= ackd_d;  oe_q <= oe_d;
      trx_q <= trx_d;  bb_q <= bb_d;  pin_q <= pin_d;
      aas_q <= aas_d;  gc_q <= gc_d;  lrb_q <= lrb_d;
    end
  end

  always_comb begin
    status = {1'b0, trx_q, bb_q, pin_q, 1'b0, aas_q, gc_q, lrb_q};
    sda_oe = oe_q;
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2cbe_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SAW = DW - 1,
  localparam int BCW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          tmo_set,
  output logic          sda_oe,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] data_q,
  output logic [7:0]    status,
  output logic          tmo_flag,
  output logic          irq
);
  logic [1:0]     rst_pipe_q;
  logic           rst_n_s;
  logic           scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic           clr_bc, dat_we, int_clr;
  logic [SAW-1:0] slv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  i2cbe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cbe_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .clr_bc(clr_bc), .tmo_set(tmo_set), .ctrl_q(ctrl_q), .slv_q(slv_q),
    .tmo_q(tmo_flag), .dat_we(dat_we), .int_clr(int_clr)
  );

  i2cbe_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .int_clr(int_clr), .start_det(start_det),
    .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .bc(ctrl_q[BCW-1:0]), .free_fmt(ctrl_q[CTL_FREE]), .ack_clk(ctrl_q[CTL_ACKCLK]),
    .slv(slv_q), .dat_we(dat_we), .dat_wdata(reg_wdata), .clr_bc(clr_bc),
    .data_q(data_q), .status(status), .sda_oe(sda_oe)
  );

  assign irq = ~status[4];
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic [7:0] ctrl_q,
  input logic [7:0] status,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       irq
);
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl_q[3] |=> (status == 8'h10) && !sda_oe);

  assert_srst_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_q[6] |=> !ctrl_q[6] && (status == 8'h10));

  assert_start_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(status[5]) |-> (ctrl_q[2:0] == 3'b000));

  assert_irq_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> (ctrl_q[2:0] == 3'b000));

  assert_hit_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(status[2:1]));

  assert_oe_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .ctrl_q(ctrl_q), .status(status),
  .sda_oe(sda_oe), .scl_s(scl_s), .irq(irq)
);

// File: tb/test_i2c_byte_engine.sv
`timescale 1ns/1ps
module test_i2c_byte_engine;
  localparam int H = 12;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       scl_m, sda_m, tmo_set;
  logic       sda_oe, tmo_flag, irq;
  logic [7:0] ctrl_q, data_q, status;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  i2c_byte_engine i_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scl_in(scl_m), .sda_in(sda_m & ~sda_oe),
    .tmo_set(tmo_set), .sda_oe(sda_oe), .ctrl_q(ctrl_q), .data_q(data_q),
    .status(status), .tmo_flag(tmo_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0; w(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  // one SCL clock, returns sda_oe sampled in the middle of the high phase
  task automatic clk_bit(input logic b, output logic oe_seen);
    sda_m = b; w(H); scl_m = 1'b1; w(H / 2); oe_seen = sda_oe;
    w(H / 2); scl_m = 1'b0; w(H);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic dummy;
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i], dummy);
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h10);
    check("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 data", data_q, 8'h00);
    check("R1 ctrl", ctrl_q, 8'h00);
  endtask

  task automatic t_addr_and_count();
    logic oe;
    wr(2'd1, 8'h2A);
    wr(2'd0, 8'h2B);                       // enable, ack clock, bit count 3
    bus_start();
    check("R2 busy after start", {7'b0, status[5]}, 8'h01);
    check("R2 count forced", {5'b0, ctrl_q[2:0]}, 8'h00);
    send_bits(8'h54, 8);
    clk_bit(1'b1, oe);
    check("R5 address ack", {7'b0, oe}, 8'h01);
    check("R3 irq", {7'b0, irq}, 8'h01);
    check("R3 own hit", {7'b0, status[2]}, 8'h01);
    check("R3 direction", {7'b0, status[6]}, 8'h00);
    check("R3 data", data_q, 8'h54);
    wr(2'd2, 8'h00);
    check("R10 irq cleared", {7'b0, irq}, 8'h00);
    check("R10 not-pending bit", {7'b0, status[4]}, 8'h01);
    wr(2'd0, 8'h2D);                       // 5 bits
    send_bits(8'h16, 5);
    clk_bit(1'b1, oe);
    check("R6 short ack", {7'b0, oe}, 8'h01);
    check("R6 short data", data_q, 8'h16);
    check("R6 count rewound", {5'b0, ctrl_q[2:0]}, 8'h00);
    check("R6 irq", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    send_bits(8'hC3, 8);
    clk_bit(1'b1, oe);
    check("R6 full byte", data_q, 8'hC3);
    bus_stop();
    check("R2 busy after stop", {7'b0, status[5]}, 8'h00);
  endtask

  task automatic t_no_ack_clock();
    wr(2'd0, 8'h08);
    wr(2'd2, 8'h00);
    bus_start();
    send_bits(8'h54, 8);
    check("R5 irq on last bit", {7'b0, irq}, 8'h01);
    check("R5 no ack data", data_q, 8'h54);
    wr(2'd2, 8'h00);
    send_bits(8'h99, 8);
    check("R5 second byte", data_q, 8'h99);
    check("R5 no extra clock oe", {7'b0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_mismatch_and_gc();
    logic oe;
    wr(2'd0, 8'h28);
    wr(2'd2, 8'h00);
    bus_start();
    send_bits(8'h56, 8);
    clk_bit(1'b1, oe);
    check("R4 mismatch no ack", {7'b0, oe}, 8'h00);
    check("R4 mismatch no irq", {7'b0, irq}, 8'h00);
    send_bits(8'h11, 8);
    clk_bit(1'b1, oe);
    check("R4 data ignored", data_q, 8'h00);
    check("R4 still no irq", {7'b0, irq}, 8'h00);
    bus_stop();
    wr(2'd2, 8'hEE);
    bus_start();
    send_bits(8'h00, 8);
    clk_bit(1'b1, oe);
    check("R4 general call ack", {7'b0, oe}, 8'h01);
    check("R4 general call flags", {6'b0, status[2:1]}, 8'h01);
    check("R4 general call data", data_q, 8'h00);
    bus_stop();
  endtask

  task automatic t_read();
    logic oe;
    logic [7:0] seen;
    wr(2'd2, 8'hA5);
    bus_start();
    send_bits(8'h55, 8);
    clk_bit(1'b1, oe);
    check("R11 read address ack", {7'b0, oe}, 8'h01);
    check("R11 direction set", {7'b0, status[6]}, 8'h01);
    check("R11 data kept", data_q, 8'hA5);
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, oe);
      seen[i] = oe;
    end
    check("R11 driven bits", seen, 8'h5A);
    clk_bit(1'b0, oe);
    check("R11 master ack released", {7'b0, oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_free();
    logic oe;
    wr(2'd0, 8'h38);
    wr(2'd2, 8'h00);
    bus_start();
    send_bits(8'h77, 8);
    clk_bit(1'b1, oe);
    check("R7 first byte ack", {7'b0, oe}, 8'h01);
    check("R7 first byte data", data_q, 8'h77);
    check("R7 irq", {7'b0, irq}, 8'h01);
    check("R7 no address flags", {6'b0, status[2:1]}, 8'h00);
    wr(2'd2, 8'h00);
    send_bits(8'h01, 8);
    clk_bit(1'b1, oe);
    check("R7 second byte", data_q, 8'h01);
  endtask

  task automatic t_disable();
    @(negedge clk); tmo_set = 1'b1; @(negedge clk); tmo_set = 1'b0;
    check("R8 timeout set", {7'b0, tmo_flag}, 8'h01);
    wr(2'd0, 8'h00);
    w(2);
    check("R8 status idle", status, 8'h10);
    check("R8 oe released", {7'b0, sda_oe}, 8'h00);
    check("R8 timeout cleared", {7'b0, tmo_flag}, 8'h00);
    wr(2'd2, 8'h3C);
    w(1);
    check("R8 data write ignored", data_q, 8'h01);
    bus_stop();
  endtask

  task automatic t_soft_reset();
    wr(2'd0, 8'h28);
    @(negedge clk); tmo_set = 1'b1; @(negedge clk); tmo_set = 1'b0;
    bus_start();
    check("R9 busy before", {7'b0, status[5]}, 8'h01);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h68;
    @(negedge clk);
    reg_we = 1'b0;
    w(2);
    check("R9 bit self-cleared", ctrl_q, 8'h28);
    check("R9 status idle", status, 8'h10);
    check("R9 timeout cleared", {7'b0, tmo_flag}, 8'h00);
    bus_stop();
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    scl_m = 1'b1; sda_m = 1'b1; tmo_set = 1'b0;
    w(5);
    rst_n = 1'b1;
    w(5);
    t_reset();
    t_addr_and_count();
    t_no_ack_clock();
    t_mismatch_and_gc();
    t_read();
    t_free();
    t_disable();
    t_soft_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule